// File: doc/BRIEF.md
# Converter Serial Port Slave

This block is the digital serial front end of a multichannel 16-bit successive-approximation converter. A host reaches it through a chip select, a serial clock, a data input and a data output with its own output enable. A DSP host can also use a frame-sync input, and it sees a frame-sync output that marks the start of the result. A converter core, modelled as a parallel 16-bit word plus a done strobe, supplies the results. The block drives a wake pulse and a shutdown level back to the analog side.

A fast system clock oversamples every serial pin through two-flop synchronizers, and edge detectors turn the pins into events. In SPI-style framing the frame opens when chip select falls, and data-input bits are taken on rising serial-clock edges. In DSP framing, once chip select is low, the frame opens at the falling serial-clock edge that samples the frame-sync input high, and data-input bits are taken on falling edges. In both framings the first eight data-input bits form a command byte, which the block latches and presents with a valid strobe. The data output stays low for a fixed count of falling edges set by the transfer-width select. The latest converter result then leaves MSB first in straight binary, one bit per falling edge.

Top module: `sar_serial_port`

## Requirements
- R1: While cs_n is high, core_shutdown is high. Each falling edge of cs_n produces exactly one single-cycle core_wake pulse, and core_shutdown is low during that pulse.
- R2: dout_oe equals the inverse of cs_n at all times, so the data output is released whenever chip select is high.
- R3: Within a frame, counting falling serial-clock edges from 1 (in DSP framing, from the edge after the one that sampled the frame sync), dout is low after every edge before edge N. Here N is 8 when width16 is 0 and 16 when width16 is 1.
- R4: With width16 = 0, result bit 15 appears on dout after falling edge 8, and bits 14 down to 0 follow on edges 9 to 23.
- R5: With width16 = 1, result bit 15 appears on dout after falling edge 16, and bits 14 down to 0 follow on edges 17 to 31.
- R6: After edge N+15, dout returns low and stays low for any further serial-clock edges in the same frame. The 8-bit frame therefore spans 24 falling edges.
- R7: The word shifted out is the conv_data value captured at the most recent conv_done strobe.
- R8: With dsp_mode = 0, din is sampled on rising serial-clock edges. The first eight bits, MSB first, appear on cmd_byte together with a single-cycle cmd_valid pulse, and later din bits in the frame have no effect on cmd_byte.
- R9: With dsp_mode = 1, falling edges before the one that samples fsync_in high are ignored. din is then sampled on the next eight falling edges to form cmd_byte, MSB first.
- R10: In DSP framing, fsync_out goes high after the falling edge that presents result bit 15 and goes low after the next falling edge. In SPI framing it stays low.
- R11: A rise of cs_n in mid-frame abandons the frame. No cmd_valid is issued if fewer than eight command bits had arrived, dout goes low, and the next frame starts again from edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data from the host |
| fsync_in | input | 1 | DSP frame-sync input |
| dsp_mode | input | 1 | 1 selects DSP framing, 0 selects SPI-style framing |
| width16 | input | 1 | 1 selects 16-bit transfer, 0 selects 8-bit transfer |
| conv_data | input | 16 | Result word from the converter core |
| conv_done | input | 1 | Strobe that captures conv_data |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout |
| fsync_out | output | 1 | Pulse marking the result MSB in DSP framing |
| core_wake | output | 1 | Single-cycle wake pulse to the analog core |
| core_shutdown | output | 1 | Shutdown level to the analog core |
| cmd_byte | output | 8 | Last complete command byte |
| cmd_valid | output | 1 | Single-cycle strobe for a new cmd_byte |

## Verification
The bench checks dout after every falling edge in both transfer widths and both framings. An off-by-one edge counter would present the MSB one edge early or late, and a wrong width decode would put the 8-bit MSB at edge 16. Extra edges run past the end of each frame so that a shifter that never stops or wraps is exposed. In DSP framing the bench supplies falling edges before the frame sync, so a design that counts them would shift its output early. Frames are aborted both inside the command byte and inside the result, so a design that keeps stale counts or shifter contents would either raise a spurious cmd_valid or leak old bits into the next frame.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    localparam int RES_W = 16;
    localparam int CMD_W = 8;
    localparam int CNT_W = 6;
    localparam int CMD_CNT_W = $clog2(CMD_W + 1);
    localparam int PIN_W = 4;

    // pin positions inside the synchronized vector
    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_DIN  = 2;
    localparam int PIN_FS   = 3;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_ARMED  = 2'd1,
        PS_ACTIVE = 2'd2,
        PS_DONE   = 2'd3
    } port_state_e;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_fall;
        logic cs_high;
        logic din;
        logic fsync;
    } pin_events_t;

    // falling edge on which the result MSB is presented
    function automatic logic [CNT_W-1:0] msb_edge(input logic wide);
        return wide ? CNT_W'(16) : CNT_W'(8);
    endfunction

    // falling edge on which the frame is complete
    function automatic logic [CNT_W-1:0] last_edge(input logic wide);
        return msb_edge(wide) + CNT_W'(RES_W);
    endfunction

endpackage

// File: rtl/sar_port_sync.sv
module sar_port_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= RST_VAL[i];
                stage2[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= d[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign q = stage2;
endmodule

// File: rtl/sar_port_events.sv
module sar_port_events
    import sar_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        din,
    input  logic        fsync_in,
    output pin_events_t ev
);
    localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_CS;

    logic [PIN_W-1:0] raw_pins;
    logic [PIN_W-1:0] sync_pins;
    logic             sclk_prev;
    logic             cs_prev;

    always_comb begin
        raw_pins           = '0;
        raw_pins[PIN_CS]   = cs_n;
        raw_pins[PIN_SCLK] = sclk;
        raw_pins[PIN_DIN]  = din;
        raw_pins[PIN_FS]   = fsync_in;
    end

    sar_port_sync #(
        .W       (PIN_W),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= sync_pins[PIN_SCLK];
            cs_prev   <= sync_pins[PIN_CS];
        end
    end

    always_comb begin
        ev.sclk_rise = sync_pins[PIN_SCLK] & ~sclk_prev;
        ev.sclk_fall = ~sync_pins[PIN_SCLK] & sclk_prev;
        ev.cs_fall   = ~sync_pins[PIN_CS] & cs_prev;
        ev.cs_high   = sync_pins[PIN_CS];
        ev.din       = sync_pins[PIN_DIN];
        ev.fsync     = sync_pins[PIN_FS];
    end
endmodule

// File: rtl/sar_port_frame.sv
module sar_port_frame
    import sar_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dsp_mode,
    input  logic             width16,
    input  logic             cs_high,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             fsync,
    input  logic [RES_W-1:0] result,
    output logic             frame_start,
    output logic             cmd_strobe,
    output logic             dout,
    output logic             fsync_out
);
    port_state_e      state;
    logic [CNT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] fall_next;
    logic [RES_W-1:0] shreg;

    assign fall_next = fall_cnt + CNT_W'(1);

    always_comb begin
        frame_start = 1'b0;
        if (!cs_high) begin
            if (state == PS_IDLE && !dsp_mode)
                frame_start = 1'b1;
            else if (state == PS_ARMED && sclk_fall && fsync)
                frame_start = 1'b1;
        end
    end

    assign cmd_strobe = !cs_high && (state == PS_ACTIVE) &&
                        (dsp_mode ? sclk_fall : sclk_rise);

    always_ff @(posedge clk) begin
        if (rst || cs_high) begin
            state     <= PS_IDLE;
            fall_cnt  <= '0;
            shreg     <= '0;
            fsync_out <= 1'b0;
        end else begin
            case (state)
                PS_IDLE: begin
                    fall_cnt <= '0;
                    shreg    <= '0;
                    state    <= dsp_mode ? PS_ARMED : PS_ACTIVE;
                end
                PS_ARMED: begin
                    if (sclk_fall && fsync) begin
                        fall_cnt <= '0;
                        shreg    <= '0;
                        state    <= PS_ACTIVE;
                    end
                end
                PS_ACTIVE: begin
                    if (sclk_fall) begin
                        fall_cnt  <= fall_next;
                        fsync_out <= 1'b0;
                        if (fall_next == msb_edge(width16)) begin
                            shreg     <= result;
                            fsync_out <= dsp_mode;
                        end else begin
                            shreg <= {shreg[RES_W-2:0], 1'b0};
                        end
                        if (fall_next == last_edge(width16))
                            state <= dsp_mode ? PS_ARMED : PS_DONE;
                    end
                end
                default: begin
                    state <= PS_DONE;
                end
            endcase
        end
    end

    assign dout = shreg[RES_W-1];
endmodule

// File: rtl/sar_port_cmd.sv
module sar_port_cmd
    import sar_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             strobe,
    input  logic             din,
    output logic [CMD_W-1:0] cmd_byte,
    output logic             cmd_valid
);
    logic [CMD_CNT_W-1:0] bit_cnt;
    logic [CMD_W-1:0]     shift;
    logic [CMD_W-1:0]     shift_next;

    assign shift_next = {shift[CMD_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            shift     <= '0;
            cmd_byte  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
                shift   <= '0;
            end else if (strobe && bit_cnt < CMD_CNT_W'(CMD_W)) begin
                shift   <= shift_next;
                bit_cnt <= bit_cnt + CMD_CNT_W'(1);
                if (bit_cnt == CMD_CNT_W'(CMD_W - 1)) begin
                    cmd_byte  <= shift_next;
                    cmd_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sar_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             fsync_in,
    input  logic             dsp_mode,
    input  logic             width16,
    input  logic [RES_W-1:0] conv_data,
    input  logic             conv_done,
    output logic             dout,
    output logic             dout_oe,
    output logic             fsync_out,
    output logic             core_wake,
    output logic             core_shutdown,
    output logic [CMD_W-1:0] cmd_byte,
    output logic             cmd_valid
);
    pin_events_t      ev;
    logic [RES_W-1:0] result_q;
    logic             frame_start;
    logic             cmd_strobe;

    sar_port_events u_events (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .din      (din),
        .fsync_in (fsync_in),
        .ev       (ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q      <= '0;
            core_wake     <= 1'b0;
            core_shutdown <= 1'b1;
        end else begin
            if (conv_done)
                result_q <= conv_data;
            core_wake     <= ev.cs_fall;
            core_shutdown <= ev.cs_high;
        end
    end

    sar_port_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .dsp_mode    (dsp_mode),
        .width16     (width16),
        .cs_high     (ev.cs_high),
        .sclk_rise   (ev.sclk_rise),
        .sclk_fall   (ev.sclk_fall),
        .fsync       (ev.fsync),
        .result      (result_q),
        .frame_start (frame_start),
        .cmd_strobe  (cmd_strobe),
        .dout        (dout),
        .fsync_out   (fsync_out)
    );

    sar_port_cmd u_cmd (
        .clk       (clk),
        .rst       (rst),
        .clear     (frame_start | ev.cs_high),
        .strobe    (cmd_strobe),
        .din       (ev.din),
        .cmd_byte  (cmd_byte),
        .cmd_valid (cmd_valid)
    );

    assign dout_oe = ~cs_n;
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk (
    input logic clk,
    input logic rst,
    input logic dout,
    input logic fsync_out,
    input logic core_wake,
    input logic core_shutdown,
    input logic cmd_valid
);
    // R1: the wake pulse lasts one cycle
    a_r1_wake_single: assert property (@(posedge clk) disable iff (rst)
        core_wake |=> !core_wake);

    // R1: no wake while the core is held in shutdown
    a_r1_wake_awake: assert property (@(posedge clk) disable iff (rst)
        core_wake |-> !core_shutdown);

    // R11: a shutdown leaves the data line low
    a_r11_low_in_shutdown: assert property (@(posedge clk) disable iff (rst)
        core_shutdown |-> !dout);

    // R10: the frame-sync marker only inside a live frame
    a_r10_fsync_live: assert property (@(posedge clk) disable iff (rst)
        fsync_out |-> !core_shutdown);

    // R10: the marker lasts one serial-clock period, never a single system cycle
    a_r10_fsync_width: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync_out) |=> fsync_out);

    // R8: one strobe per command byte
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
endmodule

bind sar_serial_port sar_serial_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .dout          (dout),
    .fsync_out     (fsync_out),
    .core_wake     (core_wake),
    .core_shutdown (core_shutdown),
    .cmd_valid     (cmd_valid)
);

// File: tb/sar_serial_port_bench.sv
module sar_serial_port_bench;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, sclk, din, fsync_in, dsp_mode, width16, conv_done;
    logic [15:0] conv_data;
    logic        dout, dout_oe, fsync_out, core_wake, core_shutdown, cmd_valid;
    logic [7:0]  cmd_byte;

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    int wake_seen = 0;
    logic [7:0] valid_byte = 8'h00;

    always #4 clk = ~clk;

    sar_serial_port u_sar_serial_port (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .din (din),
        .fsync_in (fsync_in), .dsp_mode (dsp_mode), .width16 (width16),
        .conv_data (conv_data), .conv_done (conv_done), .dout (dout),
        .dout_oe (dout_oe), .fsync_out (fsync_out), .core_wake (core_wake),
        .core_shutdown (core_shutdown), .cmd_byte (cmd_byte), .cmd_valid (cmd_valid)
    );

    always @(posedge clk) begin
        if (cmd_valid) begin
            valid_seen = valid_seen + 1;
            valid_byte = cmd_byte;
        end
        if (core_wake) wake_seen = wake_seen + 1;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic w16, input logic [15:0] s, input int k);
        int n;
        n = w16 ? 16 : 8;
        if (k >= n && k < n + 16) return s[15 - (k - n)];
        return 1'b0;
    endfunction

    // one serial-clock period; returns sampled just before the next period
    task automatic sclk_cycle(input logic d, input logic fs);
        din = d;
        fsync_in = fs;
        repeat (HALF) @(posedge clk);
        @(negedge clk) sclk = 1'b1;
        repeat (HALF) @(posedge clk);
        @(negedge clk) sclk = 1'b0;
        repeat (HALF - 1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input logic dsp, input logic w16, input logic [7:0] cmd,
                             input logic [15:0] s, input int nfall);
        int n;
        int v0;
        int w0;
        n = w16 ? 16 : 8;
        @(negedge clk);
        conv_data = s;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        conv_data = ~s;
        dsp_mode = dsp;
        width16 = w16;
        v0 = valid_seen;
        w0 = wake_seen;
        cs_n = 1'b0;
        #1;
        check("R2 oe low-cs", {15'd0, dout_oe}, 16'd1);
        repeat (6) @(negedge clk);
        check("R1 wake pulse", 16'(wake_seen - w0), 16'd1);
        check("R1 shutdown off", {15'd0, core_shutdown}, 16'd0);
        if (dsp) begin
            // R9: edges before the frame sync are ignored
            sclk_cycle(1'b1, 1'b0);
            sclk_cycle(1'b0, 1'b0);
            check("R9 pre-sync low", {15'd0, dout}, 16'd0);
            sclk_cycle(1'b0, 1'b1);
        end
        for (int k = 1; k <= nfall; k++) begin
            logic b;
            b = (k <= 8) ? cmd[8 - k] : 1'($urandom);
            sclk_cycle(b, 1'b0);
            if (k < n)
                check("R3 low before msb", {15'd0, dout}, 16'd0);
            else if (k < n + 16)
                check(w16 ? "R5 data bit" : "R4 data bit", {15'd0, dout}, {15'd0, exp_bit(w16, s, k)});
            else
                check("R6 low after frame", {15'd0, dout}, 16'd0);
            check("R10 fsync_out", {15'd0, fsync_out}, {15'd0, dsp && (k == n)});
        end
        if (nfall >= 8) begin
            check(dsp ? "R9 cmd count" : "R8 cmd count", 16'(valid_seen - v0), 16'd1);
            check(dsp ? "R9 cmd byte" : "R8 cmd byte", {8'd0, valid_byte}, {8'd0, cmd});
        end else begin
            check("R11 no cmd on abort", 16'(valid_seen - v0), 16'd0);
        end
        cs_n = 1'b1;
        #1;
        check("R2 oe high-cs", {15'd0, dout_oe}, 16'd0);
        repeat (6) @(negedge clk);
        check("R1 shutdown on", {15'd0, core_shutdown}, 16'd1);
        check("R11 dout low", {15'd0, dout}, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; fsync_in = 1'b0;
        dsp_mode = 1'b0; width16 = 1'b0; conv_done = 1'b0; conv_data = 16'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset shutdown", {15'd0, core_shutdown}, 16'd1);
        check("R2 reset oe", {15'd0, dout_oe}, 16'd0);
        check("R3 reset dout", {15'd0, dout}, 16'd0);
        check("R8 reset valid", {15'd0, cmd_valid}, 16'd0);

        // directed corners: all widths and framings, full frames with spare edges
        run_frame(1'b0, 1'b0, 8'hA5, 16'h8001, 26);  // R4 R6 R8
        run_frame(1'b0, 1'b1, 8'h3C, 16'hFFFF, 34);  // R5 R6
        run_frame(1'b1, 1'b0, 8'hC3, 16'h7FFE, 26);  // R9 R10
        run_frame(1'b1, 1'b1, 8'h81, 16'h5A5A, 34);  // R9 R10
        // R11: abort inside the command, then inside the result
        run_frame(1'b0, 1'b0, 8'hFF, 16'hFFFF, 5);
        run_frame(1'b0, 1'b0, 8'h12, 16'h1234, 24);
        run_frame(1'b1, 1'b1, 8'hF0, 16'hFFFF, 20);
        run_frame(1'b1, 1'b1, 8'h0F, 16'h8000, 32);
        // R7: a second strobe replaces the first
        @(negedge clk);
        conv_data = 16'h1111; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        run_frame(1'b0, 1'b1, 8'h55, 16'hBEEF, 32);  // R7

        // random frames
        for (int i = 0; i < 12; i++) begin
            logic dm, wm;
            dm = 1'($urandom);
            wm = 1'($urandom);
            run_frame(dm, wm, 8'($urandom), 16'($urandom), wm ? 33 : 25);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule